// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block sits between a simple request port and an 8-bit multiplexed NAND flash bus of the small-page kind. A single request names an operation (page read, block erase, status read, identifier read or device reset), a 9-bit column, a 17-bit row and, for reads, a byte count. The sequencer then drives chip enable, the command and address latch strobes, the write and read strobes and the write-protect line. It places command and address bytes on the bus, waits for the ready/busy line to complete a low-then-high cycle, and reads bytes back.

Read bytes leave on a valid/ready stream. One read strobe cycle is spent per byte, and the next strobe waits until the stream has taken the byte. When the operation ends, a one-cycle completion pulse carries a pass flag and a timeout flag. Every strobe width and gap is a clock count fixed at elaboration, so the same RTL suits any system clock.

The column's top bit selects the half-page through the read opcode and never appears as an address byte. An erase raises write-protect ahead of the erase setup command. After the device finishes, the erase reads the status byte itself and reports its result on the pass flag.

Top module: `nand_seq`

## Requirements
- R1: While idle, and out of reset, chip enable, write strobe and read strobe are high (inactive), write-protect is low, the bus is not driven, `req_ready` is high and `busy` is low.
- R2: A page read (op 0) writes command 00h when column bit 8 is 0 or 01h when it is 1, with CLE high. It then writes four address bytes with ALE high, in this order: column[7:0], row[7:0], row[15:8], and {7'b0, row[16]}.
- R3: A block erase (op 1) raises write-protect at least T_WW clocks before the first write strobe of command 60h. It writes 60h, then the three row bytes in the R2 order, then D0h. After the busy cycle it writes 70h and reads one status byte without streaming it. `done_ok` is 1 exactly when bit 0 of that byte is 0.
- R4: A status read (op 2) writes 70h and returns one byte on the read stream. `done_ok` is 1 exactly when its bit 0 is 0.
- R5: An identifier read (op 3) writes 90h and one address byte of 00h, then streams `req_len` bytes as read from the bus.
- R6: A reset (op 4) writes FFh, waits for one busy cycle and completes with `done_ok` = 1.
- R7: Every write strobe low pulse lasts exactly T_WP clocks, and the strobe stays high for at least T_WH clocks before the next one.
- R8: The first read strobe falling edge follows the last write strobe rising edge by at least T_WHR clocks.
- R9: After a page read's last address byte, after D0h and after FFh, no read strobe occurs until ready/busy has gone low and high again. If that cycle takes TIMEOUT clocks, the operation ends with `done_tmo` = 1 and `done_ok` = 0.
- R10: A page read delivers exactly `req_len` bytes in order. Each byte is one read strobe cycle. While `rd_valid` is high and `rd_ready` is low, the byte is held and no new read strobe starts. With `req_len` = 0 no byte is delivered.
- R11: `done` is a single-cycle pulse, followed by the idle state. An op code of 5 to 7 produces no bus cycle and completes with `done_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken on this cycle |
| req_op | input | 3 | 0 read, 1 erase, 2 status, 3 identifier, 4 reset |
| req_col | input | 9 | Column; bit 8 picks the half-page |
| req_row | input | 17 | Page row address |
| req_len | input | LEN_W | Bytes to read (read and identifier) |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| done_ok | output | 1 | Pass flag, valid with done |
| done_tmo | output | 1 | Busy-wait timeout, valid with done |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write protect, active low |
| nf_rb | input | 1 | Ready (1) / busy (0) |
| nf_io_out | output | 8 | Bus byte driven to the flash |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_io_in | input | 8 | Bus byte from the flash |

## Verification
A bus-level flash model logs every latched byte with its CLE and ALE state. It also measures strobe widths, the write-to-read gap and the lead of write-protect, and it answers with row- and column-dependent data. Random streams of all five operations with random columns, rows, lengths and backpressure separate the address byte order, the half-page opcode choice and dropped or duplicated stream bytes. Directed runs cover reads of the upper half with row bit 16 set, a zero length, erase and status with the fail bit set and clear, a ready/busy line stuck low for the timeout, and an unused op code. These runs separate pass from fail decoding, timeout from normal completion, and the no-bus-activity path.

// File: rtl/nand_seq.sv
`timescale 1ns/1ps
module nand_seq #(
  parameter int T_WP    = 5,
  parameter int T_WH    = 3,
  parameter int T_WHR   = 10,
  parameter int T_RP    = 5,
  parameter int T_REH   = 3,
  parameter int T_WW    = 20,
  parameter int TIMEOUT = 4000,
  parameter int LEN_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [8:0]       req_col,
  input  logic [16:0]      req_row,
  input  logic [LEN_W-1:0] req_len,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             done_ok,
  output logic             done_tmo,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic             nf_wp_n,
  input  logic             nf_rb,
  output logic [7:0]       nf_io_out,
  output logic             nf_io_oe,
  input  logic [7:0]       nf_io_in
);
  localparam int TM_A = (T_WP > T_WH) ? T_WP : T_WH;
  localparam int TM_B = (T_WHR > T_RP) ? T_WHR : T_RP;
  localparam int TM_C = (T_REH > T_WW) ? T_REH : T_WW;
  localparam int TM_D = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int TMAX = (TM_D > TM_C) ? TM_D : TM_C;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int TOW  = $clog2(TIMEOUT + 1);

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_ERASE = 3'd1;
  localparam logic [2:0] OP_STAT  = 3'd2;
  localparam logic [2:0] OP_ID    = 3'd3;
  localparam logic [2:0] OP_RST   = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_WPSU, S_CMD, S_ADDR, S_CONF, S_WAIT, S_GAP, S_READ, S_DONE
  } st_t;

  function automatic logic [CW-1:0] tload(st_t s);
    case (s)
      S_WPSU:               return CW'(T_WW - 1);
      S_CMD, S_ADDR, S_CONF: return CW'(T_WP - 1);
      S_GAP:                return CW'(T_WHR - 1);
      S_READ:               return CW'(T_RP - 1);
      default:              return '0;
    endcase
  endfunction

  st_t              st, nxt;
  logic [1:0]       ph;
  logic [CW-1:0]    tc;
  logic [TOW-1:0]   tocnt;
  logic [2:0]       op;
  logic [8:0]       col;
  logic [16:0]      row;
  logic [LEN_W-1:0] left;
  logic [1:0]       ai;
  logic             stat, ok, tmo;
  logic [1:0]       rb_q;
  logic [7:0]       rdat;

  logic       adv, tz, wdone, strm, byte_end, tmo_hit, rb_s;
  logic [7:0] cb, abyte;
  logic [2:0] naddr, aidx;

  assign tz       = (tc == '0);
  assign rb_s     = rb_q[1];
  assign wdone    = tz && (ph == 2'd1);
  assign strm     = (op != OP_ERASE);
  assign byte_end = (ph == 2'd1 && tz && !strm) || (ph == 2'd2 && rd_ready);
  assign tmo_hit  = (tocnt == TOW'(TIMEOUT - 1));
  assign naddr    = (op == OP_READ) ? 3'd4 : (op == OP_ERASE) ? 3'd3 : 3'd1;
  assign aidx     = {1'b0, ai} + ((op == OP_ERASE) ? 3'd1 : 3'd0);

  always_comb begin
    if (stat) cb = 8'h70;
    else begin
      case (op)
        OP_READ:  cb = col[8] ? 8'h01 : 8'h00;
        OP_ERASE: cb = 8'h60;
        OP_STAT:  cb = 8'h70;
        OP_ID:    cb = 8'h90;
        default:  cb = 8'hFF;
      endcase
    end
  end

  always_comb begin
    if (op == OP_ID) abyte = 8'h00;
    else begin
      case (aidx)
        3'd0:    abyte = col[7:0];
        3'd1:    abyte = row[7:0];
        3'd2:    abyte = row[15:8];
        default: abyte = {7'b0, row[16]};
      endcase
    end
  end

  assign nf_io_oe  = (st == S_CMD) || (st == S_ADDR) || (st == S_CONF);
  assign nf_io_out = (st == S_ADDR) ? abyte : (st == S_CONF) ? 8'hD0 : (st == S_CMD) ? cb : 8'h00;
  assign nf_we_n   = !(nf_io_oe && ph == 2'd0);
  assign nf_cle    = (st == S_CMD) || (st == S_CONF);
  assign nf_ale    = (st == S_ADDR);
  assign nf_re_n   = !(st == S_READ && ph == 2'd0);
  assign nf_ce_n   = (st == S_IDLE) || (st == S_WPSU) || (st == S_DONE);
  assign nf_wp_n   = (op == OP_ERASE) && (st != S_IDLE);
  assign rd_valid  = (st == S_READ) && (ph == 2'd2);
  assign rd_data   = rdat;
  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign done_ok   = ok;
  assign done_tmo  = tmo;

  always_comb begin
    adv = 1'b0;
    nxt = st;
    case (st)
      S_IDLE: if (req_valid) begin
        adv = 1'b1;
        nxt = (req_op == OP_ERASE) ? S_WPSU : (req_op > OP_RST) ? S_DONE : S_CMD;
      end
      S_WPSU: if (tz) begin adv = 1'b1; nxt = S_CMD; end
      S_CMD: if (wdone) begin
        adv = 1'b1;
        nxt = (stat || op == OP_STAT) ? S_GAP : (op == OP_RST) ? S_WAIT : S_ADDR;
      end
      S_ADDR: if (wdone && ({1'b0, ai} == naddr - 3'd1)) begin
        adv = 1'b1;
        nxt = (op == OP_READ) ? S_WAIT : (op == OP_ERASE) ? S_CONF : S_GAP;
      end
      S_CONF: if (wdone) begin adv = 1'b1; nxt = S_WAIT; end
      S_WAIT: begin
        if (tmo_hit) begin adv = 1'b1; nxt = S_DONE; end
        else if (ph == 2'd1 && rb_s) begin
          adv = 1'b1;
          nxt = (op == OP_READ) ? S_GAP : (op == OP_ERASE) ? S_CMD : S_DONE;
        end
      end
      S_GAP: if (tz) begin adv = 1'b1; nxt = (left == '0) ? S_DONE : S_READ; end
      S_READ: if (byte_end && left == LEN_W'(1)) begin adv = 1'b1; nxt = S_DONE; end
      S_DONE: begin adv = 1'b1; nxt = S_IDLE; end
      default: begin adv = 1'b1; nxt = S_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rb_q <= 2'b11;
    else        rb_q <= {rb_q[0], nf_rb};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; tc <= '0; tocnt <= '0; op <= OP_READ;
      col <= '0; row <= '0; left <= '0; ai <= '0; stat <= 1'b0;
      ok <= 1'b0; tmo <= 1'b0; rdat <= '0;
    end else if (adv) begin
      st    <= nxt;
      ph    <= '0;
      tc    <= tload(nxt);
      tocnt <= '0;
      case (st)
        S_IDLE: begin
          op <= req_op; col <= req_col; row <= req_row;
          left <= (req_op == OP_STAT) ? LEN_W'(1) : req_len;
          ai <= '0; stat <= 1'b0; ok <= 1'b0; tmo <= 1'b0;
        end
        S_WAIT: begin
          if (tmo_hit) begin tmo <= 1'b1; ok <= 1'b0; end
          else if (op == OP_ERASE) begin stat <= 1'b1; left <= LEN_W'(1); end
          else if (op == OP_RST) ok <= 1'b1;
        end
        S_GAP:  ok <= 1'b1;
        S_READ: ok <= (op == OP_STAT || op == OP_ERASE) ? !rdat[0] : 1'b1;
        default: ;
      endcase
    end else begin
      if (!tz) tc <= tc - 1'b1;
      case (st)
        S_CMD, S_ADDR, S_CONF: begin
          if (tz && ph == 2'd0) begin ph <= 2'd1; tc <= CW'(T_WH - 1); end
          else if (wdone) begin ai <= ai + 1'b1; ph <= 2'd0; tc <= CW'(T_WP - 1); end
        end
        S_WAIT: begin
          tocnt <= tocnt + 1'b1;
          if (ph == 2'd0 && !rb_s) ph <= 2'd1;
        end
        S_READ: begin
          if (ph == 2'd0 && tz) begin
            rdat <= nf_io_in; ph <= 2'd1; tc <= CW'(T_REH - 1);
          end else if (byte_end) begin
            left <= left - 1'b1; ph <= 2'd0; tc <= CW'(T_RP - 1);
          end else if (ph == 2'd1 && tz && strm) ph <= 2'd2;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_chk.sv
`timescale 1ns/1ps
module nand_seq_chk #(
  parameter int T_WP = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_rb,
  input logic       nf_io_oe
);
  logic [15:0] lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)       lo_cnt <= '0;
    else if (!nf_we_n) lo_cnt <= lo_cnt + 1'b1;
    else              lo_cnt <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nf_ce_n && nf_we_n && nf_re_n && !nf_io_oe));
  a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  a_r7_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> (lo_cnt == 16'(T_WP)));
  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_io_oe);
  a_r9_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> nf_rb);
  a_r10_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r10_no_strobe_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> nf_re_n);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
endmodule

bind nand_seq nand_seq_chk #(.T_WP(T_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .nf_ce_n(nf_ce_n),
  .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
  .nf_rb(nf_rb), .nf_io_oe(nf_io_oe)
);

// File: tb/nand_seq_bench.sv
`timescale 1ns/1ps
module nand_seq_bench;
  localparam int TWP = 5, TWH = 3, TWHR = 10, TRP = 5, TREH = 3, TWW = 20;
  localparam int TMO = 300, BUSY_T = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, rd_ready = 1'b0;
  logic [2:0] req_op = '0;
  logic [8:0] req_col = '0;
  logic [16:0] req_row = '0;
  logic [9:0] req_len = '0;
  logic req_ready, rd_valid, busy, done, done_ok, done_tmo;
  logic [7:0] rd_data;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_rb, nf_io_oe;
  logic [7:0] nf_io_out;
  logic [7:0] nf_io_in = 8'h00;

  nand_seq #(.T_WP(TWP), .T_WH(TWH), .T_WHR(TWHR), .T_RP(TRP), .T_REH(TREH),
             .T_WW(TWW), .TIMEOUT(TMO), .LEN_W(10)) u_nand_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_col(req_col), .req_row(req_row), .req_len(req_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy),
    .done(done), .done_ok(done_ok), .done_tmo(done_tmo), .nf_ce_n(nf_ce_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_wp_n(nf_wp_n), .nf_rb(nf_rb), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
    .nf_io_in(nf_io_in));

  int n_chk = 0, n_bad = 0;
  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dfun(logic [8:0] c, logic [16:0] r, int i);
    return 8'(c[7:0] + i[7:0]) ^ r[7:0] ^ r[15:8] ^ {6'b0, r[16], c[8]};
  endfunction

  // flash model
  logic hang = 1'b0, fail_bit = 1'b0;
  logic [9:0] lg [0:1023];
  int lgn = 0, acnt = 0, ridx = 0, busy_go = 0, busy_seen = 0, busy_left = 0;
  int we_lo_bad = 0, we_hi_bad = 0, gap_bad = 0, wp_bad = 0;
  logic re_first = 1'b0;
  logic [7:0] lcmd = 8'h00;
  logic [7:0] ab [0:3];
  time t_we_fall = 0, t_we_rise = 0, t_wp_rise = 0;

  assign nf_rb = hang ? 1'b0 : (busy_left == 0);

  always @(posedge clk) begin
    if (busy_go != busy_seen) begin busy_seen <= busy_go; busy_left <= BUSY_T; end
    else if (busy_left > 0) busy_left <= busy_left - 1;
  end

  always @(posedge nf_wp_n) t_wp_rise = $time;

  always @(negedge nf_we_n) begin
    if (t_we_rise != 0 && ($time - t_we_rise) < TWH * 5) we_hi_bad++;
    t_we_fall = $time;
  end

  always @(posedge nf_we_n) begin
    if (!nf_ce_n) begin
      if (($time - t_we_fall) != TWP * 5) we_lo_bad++;
      if (lgn < 1024) lg[lgn] = {nf_cle, nf_ale, nf_io_out};
      lgn++;
      t_we_rise = $time;
      re_first = 1'b1;
      if (nf_cle) begin
        lcmd = nf_io_out; acnt = 0; ridx = 0;
        if (nf_io_out == 8'h60 && (!nf_wp_n || ($time - t_wp_rise) < (TWW + TWP) * 5)) wp_bad++;
        if (nf_io_out == 8'hD0 || nf_io_out == 8'hFF) busy_go++;
      end else if (nf_ale) begin
        ab[acnt[1:0]] = nf_io_out;
        acnt++;
        if ((lcmd == 8'h00 || lcmd == 8'h01) && acnt == 4) busy_go++;
      end
    end
  end

  always @(negedge nf_re_n) begin
    if (re_first && ($time - t_we_rise) < TWHR * 5) gap_bad++;
    re_first = 1'b0;
    #1;
    case (lcmd)
      8'h70: nf_io_in = {nf_wp_n, 1'b1, 5'b0, fail_bit};
      8'h90: nf_io_in = (ridx == 0) ? 8'hAD : (ridx == 1) ? 8'h76 : 8'(ridx);
      8'h00, 8'h01: nf_io_in = dfun({lcmd[0], ab[0]}, {ab[3][0], ab[2], ab[1]}, ridx);
      default: nf_io_in = 8'h00;
    endcase
    ridx++;
  end

  // one request, checked end to end
  task automatic do_op(logic [2:0] op, logic [8:0] c, logic [16:0] r, int len, logic fb,
                       logic stuck);
    logic [9:0] ex [0:7];
    logic [7:0] got [0:15];
    int exn = 0, gn = 0, start, nbytes, cyc = 0, b0 = 0, b1 = 0, b2 = 0, b3 = 0;
    logic got_ok = 1'b0, got_tmo = 1'b0, exp_ok;
    string tg;
    case (op)
      3'd0: tg = "R2";
      3'd1: tg = "R3";
      3'd2: tg = "R4";
      3'd3: tg = "R5";
      3'd4: tg = "R6";
      default: tg = "R11";
    endcase
    case (op)
      3'd0: begin
        ex[0] = {2'b10, c[8] ? 8'h01 : 8'h00}; ex[1] = {2'b01, c[7:0]};
        ex[2] = {2'b01, r[7:0]}; ex[3] = {2'b01, r[15:8]}; ex[4] = {2'b01, 7'b0, r[16]}; exn = 5;
      end
      3'd1: begin
        ex[0] = {2'b10, 8'h60}; ex[1] = {2'b01, r[7:0]}; ex[2] = {2'b01, r[15:8]};
        ex[3] = {2'b01, 7'b0, r[16]}; ex[4] = {2'b10, 8'hD0}; exn = stuck ? 5 : 6;
        ex[5] = {2'b10, 8'h70};
      end
      3'd2: begin ex[0] = {2'b10, 8'h70}; exn = 1; end
      3'd3: begin ex[0] = {2'b10, 8'h90}; ex[1] = {2'b01, 8'h00}; exn = 2; end
      3'd4: begin ex[0] = {2'b10, 8'hFF}; exn = 1; end
      default: exn = 0;
    endcase
    nbytes = stuck ? 0 : (op == 3'd0 || op == 3'd3) ? len : (op == 3'd2) ? 1 : 0;
    exp_ok = stuck ? 1'b0 : (op > 3'd4) ? 1'b0 : (op == 3'd1 || op == 3'd2) ? !fb : 1'b1;
    b0 = we_lo_bad; b1 = we_hi_bad; b2 = gap_bad; b3 = wp_bad;
    fail_bit = fb; hang = stuck;
    start = lgn;
    @(negedge clk);
    req_op = op; req_col = c; req_row = r; req_len = 10'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (done) begin got_ok = done_ok; got_tmo = done_tmo; break; end
      rd_ready = ($urandom % 4) != 0;
      if (rd_valid && rd_ready) begin
        if (gn < 16) got[gn] = rd_data;
        gn++;
      end
      cyc++;
      if (cyc > 5000) begin chk({tg, " hung"}, 1, 0); break; end
      @(negedge clk);
    end
    rd_ready = 1'b0;
    hang = 1'b0;
    chk({tg, " bus cycle count"}, lgn - start, exn);
    for (int i = 0; i < exn && i < lgn - start; i++)
      chk({tg, " bus cycle"}, int'(lg[start + i]), int'(ex[i]));
    chk("R10 byte count", gn, nbytes);
    for (int i = 0; i < gn && i < nbytes && i < 16; i++) begin
      if (op == 3'd0) chk("R10 read byte", got[i], dfun(c, r, i));
      else if (op == 3'd3) chk("R5 id byte", got[i], (i == 0) ? 8'hAD : (i == 1) ? 8'h76 : i);
      else chk("R4 status byte", got[i], {7'b0100000, fb});
    end
    chk({tg, " done_ok"}, got_ok, exp_ok);
    chk("R9 done_tmo", got_tmo, stuck);
    chk("R7 we low width", we_lo_bad - b0, 0);
    chk("R7 we high time", we_hi_bad - b1, 0);
    chk("R8 write-to-read gap", gap_bad - b2, 0);
    chk("R3 wp lead", wp_bad - b3, 0);
    @(negedge clk);
    chk("R1 idle after op", {nf_ce_n, nf_we_n, nf_re_n, nf_wp_n, req_ready, busy}, 6'b111010);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1 reset pins", {nf_ce_n, nf_we_n, nf_re_n, nf_wp_n, nf_io_oe, req_ready, busy, rd_valid},
        8'b11100100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle pins", {nf_ce_n, nf_we_n, nf_re_n, nf_wp_n, nf_io_oe, req_ready, busy}, 7'b1110010);
    do_op(3'd0, 9'h012, 17'h1_2345, 4, 1'b0, 1'b0);
    do_op(3'd0, 9'h1F0, 17'h1_ABCD, 3, 1'b0, 1'b0);
    do_op(3'd0, 9'h000, 17'h0_0001, 0, 1'b0, 1'b0);
    do_op(3'd3, 9'h000, 17'h0, 3, 1'b0, 1'b0);
    do_op(3'd2, 9'h000, 17'h0, 0, 1'b1, 1'b0);
    do_op(3'd2, 9'h000, 17'h0, 0, 1'b0, 1'b0);
    do_op(3'd1, 9'h000, 17'h1_0F0F, 0, 1'b0, 1'b0);
    do_op(3'd1, 9'h000, 17'h0_3300, 0, 1'b1, 1'b0);
    do_op(3'd4, 9'h000, 17'h0, 0, 1'b0, 1'b0);
    do_op(3'd0, 9'h055, 17'h0_0444, 2, 1'b0, 1'b1);
    do_op(3'd6, 9'h000, 17'h0, 2, 1'b0, 1'b0);
    for (int k = 0; k < 40; k++) begin
      logic [2:0] o;
      o = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      do_op(o, 9'($urandom), 17'($urandom), int'($urandom % 7), 1'($urandom), 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule